// File: doc/BRIEF.md
# NAND Flash Page-Read Copy Engine

This engine moves a region of raw NAND flash into on-chip RAM without processor help. After a single start request carrying a RAM destination, a flash source byte offset and a byte length, it works page by page. For each page it asserts chip enable, latches the read command, and sends one zero column byte and two row bytes under the address latch. It then waits for the flash ready/busy line and bursts one whole page of data words into a RAM write port.

The engine sends a fresh read command and a fresh address for every page. Streaming linearly past a page boundary would carry the flash into its spare area. Fixed settle intervals follow the command latch phase and the address latch phase. The read strobe low time is a parameter. With a 16-bit data bus the source byte offset is halved into a word offset, because the flash steps one word per access. A page then holds 256 words, or 512 bytes. When the length runs out, the engine releases chip enable, pulses done for one cycle and goes back to idle.

Top module: `nand_page_copier`

## Requirements
- R1: Following synchronous reset: nf_ce_n=1, nf_cle=0, nf_ale=0, nf_we_n=1, nf_re_n=1, nf_dq_oe=0, ram_we=0, done=0.
- R2: Every page opens with nf_ce_n low and nf_cle high. A single nf_we_n low pulse carries the read command value 0x00 on nf_dq_out.
- R3: After the command strobe rises, nf_cle stays high for at least SETTLE_CYC cycles. It then falls in the cycle nf_ale rises. nf_cle and nf_ale are never high together.
- R4: Under nf_ale, exactly three nf_we_n strobes carry, in order: 0x00, offset bits [15:8], offset bits [23:16]. The offset is the source byte offset divided by two on a 16-bit bus. After the last strobe, nf_ale stays high for at least SETTLE_CYC cycles before it falls.
- R5: No read strobe (nf_re_n low) happens while nf_rb is low. Data reading starts only once nf_rb is high.
- R6: Each page gets exactly PAGE_BYTES/(BUS_W/8) read strobes. Each strobe holds nf_re_n low for exactly STROBE_LOW cycles. The nf_dq_in value sampled where nf_re_n rises is written to RAM with a one-cycle ram_we.
- R7: The first RAM write goes to the start destination. Each later write goes to the previous address plus one, across page boundaries too.
- R8: Each page reissues the command and address sequence. The flash offset advances by one page (PAGE_BYTES/(BUS_W/8) units) per page, with carries reaching bit 16 and above.
- R9: After each page, PAGE_BYTES is subtracted from the remaining length. Copying continues while the result is not negative, so a length L gives floor(L/PAGE_BYTES)+1 pages (0 and 511 give 1 page, 512 and 600 give 2 pages).
- R10: At the end, done is high for exactly one cycle with nf_ce_n high and both latch enables low. The engine then stays idle.
- R11: A start request that arrives while a copy is in progress has no effect on that copy: no extra page, no extra writes, no second done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy (taken only when idle) |
| dst_addr | input | RAM_AW | First RAM word address |
| src_ofs | input | SRC_W | Flash source byte offset |
| length | input | LEN_W | Byte length control value |
| done | output | 1 | One-cycle completion pulse |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Flash write strobe, active low |
| nf_re_n | output | 1 | Flash read strobe, active low |
| nf_dq_out | output | BUS_W | Command/address value to flash |
| nf_dq_oe | output | 1 | Drive enable for nf_dq_out |
| nf_dq_in | input | BUS_W | Data from flash |
| nf_rb | input | 1 | Ready (1) / busy (0) from flash |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM write address |
| ram_wdata | output | BUS_W | RAM write data |

## Verification
The hardest case to reach is a page step whose offset increment carries out of the low row byte into the high one. The engine must then send both bytes changed on the second page. A source offset whose halved value sits at 0x1FF00 with a length of exactly 512 forces this, and it also hits the length boundary where the remaining count reaches zero and one more page must follow. The second hard case is a start request in the middle of a burst. The bench pulses start while data words are streaming and confirms that the page count, the write count and the done count stay unchanged.

// File: rtl/nand_copy_pkg.sv
package nand_copy_pkg;

  localparam logic [7:0] CMD_PAGE_READ = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMD_LO,
    S_CMD_SET,
    S_ADR_LO,
    S_ADR_HI,
    S_ADR_SET,
    S_POLL,
    S_RD_LO,
    S_RD_HI,
    S_NEXT,
    S_DONE
  } cp_state_e;

endpackage

// File: rtl/nand_copy_timer.sv
// Shared countdown used for both settle intervals and read strobe width.
module nand_copy_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/nand_copy_cursor.sv
// Tracks flash word offset, remaining length and RAM destination.
module nand_copy_cursor #(
  parameter int BUS_W      = 16,
  parameter int PAGE_BYTES = 512,
  parameter int RAM_AW     = 16,
  parameter int SRC_W      = 32,
  parameter int LEN_W      = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SRC_W-1:0]  src_ofs,
  input  logic [RAM_AW-1:0] dst_addr,
  input  logic [LEN_W-1:0]  length,
  input  logic              page_adv,
  input  logic              beat_adv,
  output logic [7:0]        row_lo,
  output logic [7:0]        row_hi,
  output logic [RAM_AW-1:0] dest,
  output logic              last_page
);

  localparam int PAGE_BEATS = PAGE_BYTES / (BUS_W / 8);

  logic [SRC_W-1:0] woff, woff_init;
  logic [LEN_W:0]   rem, rem_after;

  generate
    if (BUS_W == 16) begin : g_wide
      assign woff_init = src_ofs >> 1;
    end else begin : g_narrow
      assign woff_init = src_ofs;
    end
  endgenerate

  assign rem_after = rem - (LEN_W+1)'(PAGE_BYTES);
  assign last_page = rem_after[LEN_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      woff <= '0;
      rem  <= '0;
      dest <= '0;
    end else if (load) begin
      woff <= woff_init;
      rem  <= {1'b0, length};
      dest <= dst_addr;
    end else begin
      if (page_adv) begin
        woff <= woff + SRC_W'(PAGE_BEATS);
        rem  <= rem_after;
      end
      if (beat_adv) dest <= dest + 1'b1;
    end
  end

  assign row_lo = woff[15:8];
  assign row_hi = woff[23:16];

  logic unused_woff;
  assign unused_woff = ^{woff[SRC_W-1:24], woff[7:0]};

endmodule

// File: rtl/nand_page_copier.sv
module nand_page_copier
  import nand_copy_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int PAGE_BYTES = 512,
  parameter int SETTLE_CYC = 20,
  parameter int STROBE_LOW = 2,
  parameter int RAM_AW     = 16,
  parameter int SRC_W      = 32,
  parameter int LEN_W      = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RAM_AW-1:0] dst_addr,
  input  logic [SRC_W-1:0]  src_ofs,
  input  logic [LEN_W-1:0]  length,
  output logic              done,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [BUS_W-1:0]  nf_dq_out,
  output logic              nf_dq_oe,
  input  logic [BUS_W-1:0]  nf_dq_in,
  input  logic              nf_rb,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [BUS_W-1:0]  ram_wdata
);

  localparam int PAGE_BEATS = PAGE_BYTES / (BUS_W / 8);
  localparam int BW         = $clog2(PAGE_BEATS);
  localparam int TMAX       = (SETTLE_CYC > STROBE_LOW) ? SETTLE_CYC : STROBE_LOW;
  localparam int TW         = $clog2(TMAX + 1);

  cp_state_e         st;
  logic [1:0]        adr_idx;
  logic [BW-1:0]     beat;
  logic              last_beat;
  logic              set_load, stb_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              cur_load, page_adv, beat_adv, last_page;
  logic [7:0]        row_lo, row_hi;
  logic [RAM_AW-1:0] cur_dest;

  assign last_beat = (beat == BW'(PAGE_BEATS - 1));
  assign set_load  = (st == S_CMD_LO) || (st == S_ADR_HI && adr_idx == 2'd2);
  assign stb_load  = (st == S_POLL && nf_rb) || (st == S_RD_HI && !last_beat);
  assign tmr_val   = set_load ? TW'(SETTLE_CYC) : TW'(STROBE_LOW - 1);
  assign cur_load  = (st == S_IDLE) && start;
  assign page_adv  = (st == S_NEXT);
  assign beat_adv  = (st == S_RD_LO) && tmr_zero;

  nand_copy_timer #(.CW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (set_load | stb_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  nand_copy_cursor #(
    .BUS_W(BUS_W), .PAGE_BYTES(PAGE_BYTES), .RAM_AW(RAM_AW),
    .SRC_W(SRC_W), .LEN_W(LEN_W)
  ) u_cursor (
    .clk       (clk),
    .rst       (rst),
    .load      (cur_load),
    .src_ofs   (src_ofs),
    .dst_addr  (dst_addr),
    .length    (length),
    .page_adv  (page_adv),
    .beat_adv  (beat_adv),
    .row_lo    (row_lo),
    .row_hi    (row_hi),
    .dest      (cur_dest),
    .last_page (last_page)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      nf_ce_n   <= 1'b1;
      nf_cle    <= 1'b0;
      nf_ale    <= 1'b0;
      nf_we_n   <= 1'b1;
      nf_re_n   <= 1'b1;
      nf_dq_out <= '0;
      nf_dq_oe  <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      done      <= 1'b0;
      adr_idx   <= '0;
      beat      <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          nf_ce_n   <= 1'b0;
          nf_cle    <= 1'b1;
          nf_we_n   <= 1'b0;
          nf_dq_oe  <= 1'b1;
          nf_dq_out <= BUS_W'(CMD_PAGE_READ);
          st        <= S_CMD_LO;
        end
        S_CMD_LO: begin
          nf_we_n <= 1'b1;
          st      <= S_CMD_SET;
        end
        S_CMD_SET: if (tmr_zero) begin
          nf_cle    <= 1'b0;
          nf_ale    <= 1'b1;
          nf_we_n   <= 1'b0;
          nf_dq_out <= '0;
          adr_idx   <= '0;
          st        <= S_ADR_LO;
        end
        S_ADR_LO: begin
          nf_we_n <= 1'b1;
          st      <= S_ADR_HI;
        end
        S_ADR_HI: begin
          if (adr_idx == 2'd2) begin
            st <= S_ADR_SET;
          end else begin
            nf_we_n   <= 1'b0;
            nf_dq_out <= BUS_W'((adr_idx == 2'd0) ? row_lo : row_hi);
            adr_idx   <= adr_idx + 1'b1;
            st        <= S_ADR_LO;
          end
        end
        S_ADR_SET: if (tmr_zero) begin
          nf_ale   <= 1'b0;
          nf_dq_oe <= 1'b0;
          st       <= S_POLL;
        end
        S_POLL: if (nf_rb) begin
          nf_re_n <= 1'b0;
          beat    <= '0;
          st      <= S_RD_LO;
        end
        S_RD_LO: if (tmr_zero) begin
          nf_re_n   <= 1'b1;
          ram_we    <= 1'b1;
          ram_wdata <= nf_dq_in;
          ram_addr  <= cur_dest;
          st        <= S_RD_HI;
        end
        S_RD_HI: begin
          ram_we <= 1'b0;
          if (last_beat) begin
            st <= S_NEXT;
          end else begin
            beat    <= beat + 1'b1;
            nf_re_n <= 1'b0;
            st      <= S_RD_LO;
          end
        end
        S_NEXT: begin
          if (last_page) begin
            nf_ce_n <= 1'b1;
            done    <= 1'b1;
            st      <= S_DONE;
          end else begin
            nf_cle    <= 1'b1;
            nf_we_n   <= 1'b0;
            nf_dq_oe  <= 1'b1;
            nf_dq_out <= BUS_W'(CMD_PAGE_READ);
            st        <= S_CMD_LO;
          end
        end
        S_DONE: begin
          done <= 1'b0;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: the two latch enables are exclusive
  p_latch_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(nf_cle && nf_ale));

  // R2: a command strobe carries the read command with the chip selected
  p_cmd_byte_r2: assert property (@(posedge clk) disable iff (rst)
    (nf_cle && !nf_we_n) |-> (nf_dq_out == '0 && !nf_ce_n && nf_dq_oe));

  // R5: no read strobe follows a busy sample
  p_ready_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_POLL && !nf_rb) |=> nf_re_n);

  // R6: write and read strobes never overlap
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    !(!nf_we_n && !nf_re_n));

  // R6: RAM writes only happen in the data phase
  p_ram_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (nf_re_n && !nf_cle && !nf_ale && !nf_ce_n));

  // R10: done is a single cycle with the flash released
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_release_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (nf_ce_n && !nf_cle && !nf_ale));

  // R11: a start during a copy does not return the engine to idle
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && st != S_DONE && st != S_NEXT && start) |=> st != S_IDLE);

endmodule

// File: tb/nand_page_copier_bench.sv
module nand_page_copier_bench;

  localparam int RAM_AW = 12;
  localparam int SETTLE = 20;
  localparam int STROBE = 2;
  localparam int BEATS  = 256;
  localparam int BUSY_CYC = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [RAM_AW-1:0] dst_addr = '0;
  logic [31:0] src_ofs = '0;
  logic [23:0] length = '0;
  logic done, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, ram_we;
  logic [15:0] nf_dq_out, nf_dq_in, ram_wdata;
  logic [RAM_AW-1:0] ram_addr;
  logic rb = 1'b1;

  always #4 clk = ~clk;

  nand_page_copier #(.RAM_AW(RAM_AW)) u_nand_page_copier (
    .clk(clk), .rst(rst), .start(start), .dst_addr(dst_addr),
    .src_ofs(src_ofs), .length(length), .done(done),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out),
    .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rb(rb),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  function automatic logic [15:0] pat(input logic [7:0] r1, input logic [7:0] r2, input int k);
    return {r1 ^ r2 ^ 8'h3C, k[7:0]};
  endfunction

  // flash model and monitor state
  logic [15:0] mem [4096];
  logic [7:0]  adr_log [8][3];
  int          adr_cnt [8];
  logic [7:0]  cur_r1, cur_r2;
  int cmd_cnt, cmd_err, both_err, adr_n, cle_run, ale_run, cle_min, ale_min;
  int bcnt, rbviol, low_run, beat, strobe_err, wcnt, addr_err, done_cnt, done_err;
  logic [RAM_AW-1:0] first_addr, last_addr;
  logic prev_cle, prev_ale, prev_re;

  assign nf_dq_in = pat(cur_r1, cur_r2, beat);

  task automatic clear_mon();
    cmd_cnt = 0; cmd_err = 0; both_err = 0; adr_n = 0; cle_run = 0; ale_run = 0;
    cle_min = 1000; ale_min = 1000; rbviol = 0; low_run = 0; beat = 0;
    strobe_err = 0; wcnt = 0; addr_err = 0; done_cnt = 0; done_err = 0;
    first_addr = '0; last_addr = '0;
    for (int i = 0; i < 8; i++) begin
      adr_cnt[i] = 0;
      for (int j = 0; j < 3; j++) adr_log[i][j] = 8'hEE;
    end
    for (int i = 0; i < 4096; i++) mem[i] = 16'hDEAD;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (nf_cle && nf_ale) both_err++;
      if (nf_cle && !nf_we_n) begin
        if (nf_dq_out != 16'h0000) cmd_err++;
        cmd_cnt++; adr_n = 0; beat = 0; cle_run = 0;
      end else if (nf_cle) cle_run++;
      if (prev_cle && !nf_cle && cle_run < cle_min) cle_min = cle_run;
      if (nf_ale && !nf_we_n) begin
        if (cmd_cnt > 0 && cmd_cnt <= 8 && adr_n < 3) adr_log[cmd_cnt-1][adr_n] = nf_dq_out[7:0];
        if (adr_n == 1) cur_r1 = nf_dq_out[7:0];
        if (adr_n == 2) cur_r2 = nf_dq_out[7:0];
        adr_n++; ale_run = 0;
      end else if (nf_ale) ale_run++;
      if (prev_ale && !nf_ale) begin
        if (ale_run < ale_min) ale_min = ale_run;
        if (cmd_cnt > 0 && cmd_cnt <= 8) adr_cnt[cmd_cnt-1] = adr_n;
        rb = 1'b0; bcnt = BUSY_CYC;
      end else if (bcnt > 0) begin
        bcnt--;
        if (bcnt == 0) rb = 1'b1;
      end
      if (!nf_re_n) begin
        if (!rb) rbviol++;
        low_run++;
      end else if (!prev_re) begin
        if (low_run != STROBE) strobe_err++;
        low_run = 0; beat++;
      end
      if (ram_we) begin
        if (wcnt == 0) first_addr = ram_addr;
        else if (ram_addr != last_addr + 1'b1) addr_err++;
        last_addr = ram_addr;
        mem[ram_addr] = ram_wdata;
        wcnt++;
      end
      if (done) begin
        done_cnt++;
        if (!nf_ce_n || nf_cle || nf_ale) done_err++;
      end
    end
    prev_cle = nf_cle; prev_ale = nf_ale; prev_re = nf_re_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [RAM_AW-1:0] d, input logic [31:0] s, input logic [23:0] l);
    @(posedge clk); #2;
    dst_addr = d; src_ofs = s; length = l; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 20000) begin
      @(posedge clk); #1; n++;
    end
    chk(done_cnt != 0, "watchdog R10", n, 20000);
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk(nf_ce_n && !nf_cle && !nf_ale && nf_we_n && nf_re_n && !nf_dq_oe && !ram_we && !done,
        "R1 reset outputs",
        {nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, ram_we, done}, 8'b10011000);
    @(posedge clk); #1;
    rst = 1'b0;
    prev_cle = 1'b0; prev_ale = 1'b0; prev_re = 1'b1;
  endtask

  task automatic t_copy(input logic [RAM_AW-1:0] d, input logic [31:0] s, input logic [23:0] l);
    int pages;
    int bad;
    logic [31:0] woff;
    logic [15:0] first_bad_act, first_bad_exp;
    pages = int'(l) / 512 + 1;
    @(posedge clk); #1;
    clear_mon();
    pulse_start(d, s, l);
    wait_done();
    chk(cmd_cnt == pages, "R9 page count", cmd_cnt, pages);
    chk(cmd_err == 0, "R2 command value", cmd_err, 0);
    chk(both_err == 0, "R3 latch exclusive", both_err, 0);
    chk(cle_min >= SETTLE, "R3 CLE settle", cle_min, SETTLE);
    chk(ale_min >= SETTLE, "R4 ALE settle", ale_min, SETTLE);
    chk(rbviol == 0, "R5 read while busy", rbviol, 0);
    chk(strobe_err == 0, "R6 strobe width", strobe_err, 0);
    chk(wcnt == pages * BEATS, "R6 beat count", wcnt, pages * BEATS);
    chk(first_addr == d, "R7 first address", first_addr, d);
    chk(addr_err == 0, "R7 address step", addr_err, 0);
    chk(done_cnt == 1 && done_err == 0, "R10 done pulse", done_cnt, 1);
    chk(nf_ce_n && !nf_cle && !nf_ale, "R10 idle release", {nf_ce_n, nf_cle, nf_ale}, 3'b100);
    bad = 0; first_bad_act = '0; first_bad_exp = '0;
    for (int p = 0; p < pages && p < 8; p++) begin
      woff = (s >> 1) + 32'(p * BEATS);
      chk(adr_cnt[p] == 3, "R4 address strobes", adr_cnt[p], 3);
      chk(adr_log[p][0] == 8'h00 && adr_log[p][1] == woff[15:8] && adr_log[p][2] == woff[23:16],
          "R8 row bytes", {adr_log[p][0], adr_log[p][1], adr_log[p][2]},
          {8'h00, woff[15:8], woff[23:16]});
      for (int k = 0; k < BEATS; k++) begin
        logic [RAM_AW-1:0] a;
        a = d + RAM_AW'(p * BEATS + k);
        if (mem[a] != pat(woff[15:8], woff[23:16], k)) begin
          if (bad == 0) begin
            first_bad_act = mem[a];
            first_bad_exp = pat(woff[15:8], woff[23:16], k);
          end
          bad++;
        end
      end
    end
    chk(bad == 0, "R6 RAM data", first_bad_act, first_bad_exp);
  endtask

  task automatic t_busy_start();
    @(posedge clk); #1;
    clear_mon();
    pulse_start(12'hE00, 32'h0000_0600, 24'd0);
    repeat (300) @(posedge clk);
    pulse_start(12'h000, 32'h0000_0000, 24'd2048);
    wait_done();
    repeat (1500) @(posedge clk);
    #1;
    chk(cmd_cnt == 1, "R11 no extra page", cmd_cnt, 1);
    chk(wcnt == BEATS, "R11 write count", wcnt, BEATS);
    chk(first_addr == 12'hE00, "R11 destination kept", first_addr, 12'hE00);
    chk(done_cnt == 1, "R11 single done", done_cnt, 1);
  endtask

  initial begin
    clear_mon();
    t_reset();
    t_copy(12'h000, 32'h0001_0200, 24'd0);    // R4 halving, single page
    t_copy(12'h400, 32'h0003_FE00, 24'd512);  // R8 row carry, R9 zero-remainder boundary
    t_copy(12'h800, 32'h00A0_0000, 24'd600);  // R9 two pages
    t_copy(12'hC00, 32'h0000_0400, 24'd511);  // R9 one page below boundary
    t_busy_start();                           // R11
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule